// File: doc/BRIEF.md
# Frame-Time Decoder Clock Governor

This block steers the clock level of a video decoder from how long each frame actually takes. It times every frame from its start marker to its end marker (busy time) and every gap from an end marker to the next start marker (idle time). Each kind of sample goes into its own window of recent history. The busy window is X frames long and the idle window is Y gaps long, and each length is a separately programmable power of two up to 16. The busy average is the input to the decision to speed up. The idle average, together with a prediction of how much a slower clock would stretch decoding, is the input to the decision to slow down. A request leaves the block only after that prediction has been made.

Between frames, a pipeline-idle flag from the decoder asks for the whole decoder to be power gated. The gate request is removed as soon as the next frame-start marker arrives, so decoding resumes ungated. The block assumes that every clock request is honoured and keeps its own copy of the current level. Levels are numbered from 0 (slowest) upward, and level L is taken to run at a speed proportional to L+1.

The controller steps through five named states. WAIT_FIRST goes to DECODE on the first start marker. DECODE goes to SETTLE on an end marker. SETTLE always goes to ISSUE. ISSUE always goes to GAP. GAP goes to DECODE on a start marker.

Top module: `dec_clk_governor`

## Requirements
- R1: While reset is held and after it is released, the level output reads 0, both clock requests are low and the power-gate enable is low, until the first frame has been seen.
- R2: The busy sample of a frame is the number of clock edges from the edge that samples the accepted start marker to the edge that samples its end marker. The busy average is the sum of the last 2^cfg_busy_win_log2 samples (cfg_busy_win_log2 from 0 to 4; slots never written count as 0), shifted right by cfg_busy_win_log2.
- R3: The idle sample is the number of edges from the edge that samples an end marker to the edge that samples the next accepted start marker. It is recorded at that start marker, and it is averaged like R2 over 2^cfg_idle_win_log2 gaps.
- R4: Define the threshold T = (cfg_frame_period * cfg_raise_frac) >> 4, where cfg_raise_frac is in sixteenths. If the busy average after a frame's sample is recorded exceeds T and the level is below LEVELS-1, clk_up_req is high for exactly one cycle. That cycle starts two edges after the edge that samples the end marker.
- R5: At level LEVELS-1 no raise is requested, whatever the busy average.
- R6: When no raise is due, clk_down_req pulses, with the same timing as R4, only if three conditions hold: the level L is above 0, busy_avg <= idle_avg * L (the idle time absorbs the stretch), and busy_avg * (L+1) <= T * L (the slower level would still not trigger a raise).
- R7: Each frame produces at most one request, the two requests are never high together, and the level output steps up or down by one in the same cycle as the request and holds otherwise.
- R8: In GAP, pg_en goes high one edge after any edge at which pipe_idle is high and no start marker is present, and stays low when pipe_idle is low.
- R9: pg_en is low in the cycle after the edge that samples an accepted start marker, even while pipe_idle stays high.
- R10: pg_en stays low in DECODE, SETTLE and ISSUE regardless of pipe_idle.
- R11: An end marker outside DECODE and a start marker during DECODE, SETTLE or ISSUE are ignored: the sample being measured continues, and no request or level change results. Gaps must last at least 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle marker: decoding of a frame begins |
| frame_end | input | 1 | One-cycle marker: decoding of a frame is complete |
| pipe_idle | input | 1 | Decoder pipeline is empty |
| cfg_busy_win_log2 | input | WLOG_W | log2 of busy window length X |
| cfg_idle_win_log2 | input | WLOG_W | log2 of idle window length Y |
| cfg_frame_period | input | CNT_W | Frame period in clock cycles |
| cfg_raise_frac | input | FRAC_BITS+1 | Raise threshold as a fraction of the period, in sixteenths |
| clk_up_req | output | 1 | One-cycle request for the next faster level |
| clk_down_req | output | 1 | One-cycle request for the next slower level |
| clk_level | output | LVL_W | Level the governor believes is in effect |
| pg_en | output | 1 | Power-gate enable for the decoder |

## Verification
The bound checker watches on every cycle the properties that concern ports alone. The two requests are exclusive single-cycle pulses. The level moves by exactly one with each request and holds otherwise. There is no raise at the top level and no lowering at level 0. The gate is released after a start marker and is never asserted without a preceding idle flag. Whether a request should have been issued at all depends on the window contents and the threshold arithmetic, so only the bench's frame scenarios can show it. Those scenarios run a reference average and the decision rule, and they cover window-length changes, the idle time holding back a lowering, and ignored stray markers.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
    typedef enum logic [2:0] {
        GS_WAIT_FIRST = 3'd0,
        GS_DECODE     = 3'd1,
        GS_SETTLE     = 3'd2,
        GS_ISSUE      = 3'd3,
        GS_GAP        = 3'd4
    } gov_state_t;

    localparam int NUM_WINDOWS = 2;
    localparam int WIN_BUSY    = 0;
    localparam int WIN_IDLE    = 1;
endpackage

// File: rtl/dcg_window.sv
module dcg_window #(
    parameter int W        = 16,
    parameter int LOG2_MAX = 4,
    parameter int WLOG_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [W-1:0]      sample,
    input  logic [WLOG_W-1:0] win_log2,
    output logic [W-1:0]      avg
);
    localparam int DEPTH = 1 << LOG2_MAX;
    localparam int PTR_W = LOG2_MAX;
    localparam int SUM_W = W + LOG2_MAX;

    logic [W-1:0]      slot_q [DEPTH];
    logic [PTR_W-1:0]  wr_q;
    logic [WLOG_W-1:0] eff_log2;
    logic [SUM_W-1:0]  sum;
    logic [PTR_W-1:0]  idx;
    int                span;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (push) begin
            slot_q[wr_q] <= sample;
            wr_q         <= wr_q + PTR_W'(1);
        end
    end

    // Window sum is rebuilt from the ring each cycle, so a change of
    // window length takes effect at once without a drifting accumulator.
    always_comb begin
        eff_log2 = (win_log2 > WLOG_W'(LOG2_MAX)) ? WLOG_W'(LOG2_MAX) : win_log2;
        span     = 1 << eff_log2;
        sum      = '0;
        idx      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = wr_q - PTR_W'(k + 1);
            if (k < span) sum = sum + SUM_W'(slot_q[idx]);
        end
        avg = W'(sum >> eff_log2);
    end
endmodule

// File: rtl/dcg_predictor.sv
module dcg_predictor #(
    parameter int W         = 16,
    parameter int LEVELS    = 8,
    parameter int LVL_W     = 3,
    parameter int FRAC_BITS = 4
) (
    input  logic [W-1:0]         avg_busy,
    input  logic [W-1:0]         avg_idle,
    input  logic [LVL_W-1:0]     level,
    input  logic [W-1:0]         period,
    input  logic [FRAC_BITS:0]   raise_frac,
    output logic                 want_up,
    output logic                 want_down
);
    localparam int PW = W + FRAC_BITS + LVL_W + 2;

    logic [PW-1:0] thr;
    logic [PW-1:0] busy_now;
    logic [PW-1:0] lvl_p;
    logic [PW-1:0] slow_busy;
    logic [PW-1:0] slow_budget;
    logic [PW-1:0] idle_cover;

    // Speed of level L is taken as L+1; all ratios are cross-multiplied.
    always_comb begin
        thr         = (PW'(period) * PW'(raise_frac)) >> FRAC_BITS;
        busy_now    = PW'(avg_busy);
        lvl_p       = PW'(level);
        slow_busy   = busy_now * (lvl_p + PW'(1));
        slow_budget = thr * lvl_p;
        idle_cover  = PW'(avg_idle) * lvl_p;
        want_up     = (level != LVL_W'(LEVELS - 1)) && (busy_now > thr);
        want_down   = !want_up && (level != '0)
                      && (busy_now <= idle_cover)
                      && (slow_busy <= slow_budget);
    end
endmodule

// File: rtl/dec_clk_governor.sv
module dec_clk_governor
    import dcg_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int LEVELS       = 8,
    parameter int WIN_LOG2_MAX = 4,
    parameter int FRAC_BITS    = 4,
    localparam int LVL_W       = $clog2(LEVELS),
    localparam int WLOG_W      = $clog2(WIN_LOG2_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 frame_end,
    input  logic                 pipe_idle,
    input  logic [WLOG_W-1:0]    cfg_busy_win_log2,
    input  logic [WLOG_W-1:0]    cfg_idle_win_log2,
    input  logic [CNT_W-1:0]     cfg_frame_period,
    input  logic [FRAC_BITS:0]   cfg_raise_frac,
    output logic                 clk_up_req,
    output logic                 clk_down_req,
    output logic [LVL_W-1:0]     clk_level,
    output logic                 pg_en
);
    gov_state_t state_q, state_d;

    logic [CNT_W-1:0]  busy_cnt_q, idle_cnt_q;
    logic              win_push [NUM_WINDOWS];
    logic [CNT_W-1:0]  win_sample [NUM_WINDOWS];
    logic [CNT_W-1:0]  win_avg [NUM_WINDOWS];
    logic [WLOG_W-1:0] win_len [NUM_WINDOWS];
    logic              pred_up, pred_dn;
    logic              want_up_q, want_dn_q;
    logic              accept_start, accept_end;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + CNT_W'(1);
    endfunction

    assign accept_start = frame_start && (state_q == GS_GAP || state_q == GS_WAIT_FIRST);
    assign accept_end   = frame_end && (state_q == GS_DECODE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_WAIT_FIRST;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_WAIT_FIRST: if (frame_start) state_d = GS_DECODE;
            GS_DECODE:     if (frame_end)   state_d = GS_SETTLE;
            GS_SETTLE:                      state_d = GS_ISSUE;
            GS_ISSUE:                       state_d = GS_GAP;
            GS_GAP:        if (frame_start) state_d = GS_DECODE;
            default:                        state_d = GS_WAIT_FIRST;
        endcase
    end

    // Duration counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt_q <= '0;
            idle_cnt_q <= '0;
        end else begin
            if (accept_start)              busy_cnt_q <= '0;
            else if (state_q == GS_DECODE) busy_cnt_q <= sat_inc(busy_cnt_q);

            if (accept_end) idle_cnt_q <= '0;
            else if (state_q == GS_SETTLE || state_q == GS_ISSUE
                     || (state_q == GS_GAP && !frame_start))
                idle_cnt_q <= sat_inc(idle_cnt_q);
        end
    end

    always_comb begin
        win_push[WIN_BUSY]   = accept_end;
        win_sample[WIN_BUSY] = sat_inc(busy_cnt_q);
        win_len[WIN_BUSY]    = cfg_busy_win_log2;
        win_push[WIN_IDLE]   = frame_start && (state_q == GS_GAP);
        win_sample[WIN_IDLE] = sat_inc(idle_cnt_q);
        win_len[WIN_IDLE]    = cfg_idle_win_log2;
    end

    for (genvar g = 0; g < NUM_WINDOWS; g++) begin : g_win
        dcg_window #(
            .W        (CNT_W),
            .LOG2_MAX (WIN_LOG2_MAX),
            .WLOG_W   (WLOG_W)
        ) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (win_push[g]),
            .sample   (win_sample[g]),
            .win_log2 (win_len[g]),
            .avg      (win_avg[g])
        );
    end

    dcg_predictor #(
        .W         (CNT_W),
        .LEVELS    (LEVELS),
        .LVL_W     (LVL_W),
        .FRAC_BITS (FRAC_BITS)
    ) u_pred (
        .avg_busy   (win_avg[WIN_BUSY]),
        .avg_idle   (win_avg[WIN_IDLE]),
        .level      (clk_level),
        .period     (cfg_frame_period),
        .raise_frac (cfg_raise_frac),
        .want_up    (pred_up),
        .want_down  (pred_dn)
    );

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_up_q    <= 1'b0;
            want_dn_q    <= 1'b0;
            clk_up_req   <= 1'b0;
            clk_down_req <= 1'b0;
            clk_level    <= '0;
            pg_en        <= 1'b0;
        end else begin
            clk_up_req   <= 1'b0;
            clk_down_req <= 1'b0;
            if (state_q == GS_SETTLE) begin
                want_up_q <= pred_up;
                want_dn_q <= pred_dn;
            end
            if (state_q == GS_ISSUE) begin
                clk_up_req   <= want_up_q;
                clk_down_req <= want_dn_q;
                if (want_up_q)      clk_level <= clk_level + LVL_W'(1);
                else if (want_dn_q) clk_level <= clk_level - LVL_W'(1);
            end
            pg_en <= (state_q == GS_GAP) && pipe_idle && !frame_start;
        end
    end
endmodule

// File: rtl/dcg_checker.sv
module dcg_checker #(
    parameter int LEVELS = 8,
    parameter int LVL_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             pipe_idle,
    input logic             clk_up_req,
    input logic             clk_down_req,
    input logic [LVL_W-1:0] clk_level,
    input logic             pg_en
);
    a_r7_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_up_req && clk_down_req));

    a_r4_up_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clk_up_req |=> !clk_up_req);

    a_r6_down_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clk_down_req |=> !clk_down_req);

    a_r7_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        clk_up_req |-> clk_level == $past(clk_level) + LVL_W'(1));

    a_r7_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        clk_down_req |-> clk_level == $past(clk_level) - LVL_W'(1));

    a_r7_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_up_req && !clk_down_req) |-> $stable(clk_level));

    a_r5_no_up_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        clk_up_req |-> $past(clk_level) != LVL_W'(LEVELS - 1));

    a_r6_no_down_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clk_down_req |-> $past(clk_level) != '0);

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !pg_en);

    a_r8_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pg_en |-> $past(pipe_idle));
endmodule

bind dec_clk_governor dcg_checker #(
    .LEVELS (LEVELS),
    .LVL_W  (LVL_W)
) u_dcg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .pipe_idle    (pipe_idle),
    .clk_up_req   (clk_up_req),
    .clk_down_req (clk_down_req),
    .clk_level    (clk_level),
    .pg_en        (pg_en)
);

// File: tb/dec_clk_governor_test.sv
module dec_clk_governor_test;
    localparam int CLK_PERIOD = 10;
    localparam int LEVELS     = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_start, frame_end, pipe_idle;
    logic [2:0] cfg_busy_win_log2, cfg_idle_win_log2;
    logic [15:0] cfg_frame_period;
    logic [4:0] cfg_raise_frac;
    logic       clk_up_req, clk_down_req, pg_en;
    logic [2:0] clk_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int bh[256];
    int ih[256];
    int nb = 0, ni = 0;
    int exp_level = 0;
    bit have_gap = 0;
    int last_gap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dec_clk_governor uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .pipe_idle(pipe_idle), .cfg_busy_win_log2(cfg_busy_win_log2),
        .cfg_idle_win_log2(cfg_idle_win_log2), .cfg_frame_period(cfg_frame_period),
        .cfg_raise_frac(cfg_raise_frac), .clk_up_req(clk_up_req),
        .clk_down_req(clk_down_req), .clk_level(clk_level), .pg_en(pg_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic int win_avg_b(input int lg);
        int s = 0;
        for (int k = 0; k < (1 << lg); k++) if (nb - 1 - k >= 0) s += bh[nb - 1 - k];
        return s >> lg;
    endfunction

    function automatic int win_avg_i(input int lg);
        int s = 0;
        for (int k = 0; k < (1 << lg); k++) if (ni - 1 - k >= 0) s += ih[ni - 1 - k];
        return s >> lg;
    endfunction

    // One frame: busy b edges, gap g edges (g >= 6 when stray is set).
    task automatic run_frame(input int b, input int g, input bit gap_idle,
                             input bit dec_idle, input bit stray, input string tag);
        int ab, ai, thr, eu, ed;
        if (have_gap) begin ih[ni] = last_gap; ni++; end
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        chk(pg_en === 1'b0, {tag, " R9 gate released after start"}, pg_en, 0);
        pipe_idle = dec_idle;
        for (int k = 1; k < b; k++) begin
            if (stray && k == b / 2) frame_start = 1'b1; // R11 stray start
            @(negedge clk);
            frame_start = 1'b0;
            chk(pg_en === 1'b0, {tag, " R10 no gate while decoding"}, pg_en, 0);
        end
        frame_end = 1'b1;
        bh[nb] = b; nb++;
        ab  = win_avg_b(int'(cfg_busy_win_log2));
        ai  = win_avg_i(int'(cfg_idle_win_log2));
        thr = (int'(cfg_frame_period) * int'(cfg_raise_frac)) >> 4;
        eu  = (exp_level < LEVELS - 1 && ab > thr) ? 1 : 0;
        ed  = (!eu && exp_level > 0 && ab <= ai * exp_level
               && ab * (exp_level + 1) <= thr * exp_level) ? 1 : 0;
        exp_level = exp_level + eu - ed;
        @(negedge clk);
        frame_end = 1'b0;
        pipe_idle = gap_idle;
        chk(!clk_up_req && !clk_down_req, {tag, " R4 no early request"},
            int'(clk_up_req) + int'(clk_down_req), 0);
        for (int i = 1; i < g; i++) begin
            if (stray && i == g - 2) frame_end = 1'b1; // R11 stray end
            @(negedge clk);
            frame_end = 1'b0;
            if (i == 2) begin
                chk(clk_up_req === eu[0], {tag, " R4 R5 raise decision"}, clk_up_req, eu);
                chk(clk_down_req === ed[0], {tag, " R6 lower decision"}, clk_down_req, ed);
                chk(int'(clk_level) == exp_level, {tag, " R7 level after request"},
                    clk_level, exp_level);
            end
            if (i >= 3) begin
                chk(!clk_up_req && !clk_down_req, {tag, " R7 R11 single request per frame"},
                    int'(clk_up_req) + int'(clk_down_req), 0);
                chk(pg_en === gap_idle, {tag, " R8 gate follows idle in gap"}, pg_en, gap_idle);
            end
        end
        chk(int'(clk_level) == exp_level, {tag, " R7 R11 level held in gap"}, clk_level, exp_level);
        have_gap = 1;
        last_gap = g;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; frame_start = 0; frame_end = 0; pipe_idle = 1;
        cfg_busy_win_log2 = 3'd1; cfg_idle_win_log2 = 3'd2;
        cfg_frame_period = 16'd200; cfg_raise_frac = 5'd12;
        repeat (3) @(negedge clk);
        chk(clk_level === 3'd0 && !pg_en, "R1 during reset", clk_level, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(clk_level === 3'd0, "R1 level after reset", clk_level, 0);
        chk(!clk_up_req && !clk_down_req, "R1 no request after reset",
            int'(clk_up_req) + int'(clk_down_req), 0);
        chk(pg_en === 1'b0, "R1 no gate before first frame", pg_en, 0);
    endtask

    task automatic t_raise();
        for (int f = 0; f < 9; f++) run_frame(180, 20, 1, 0, 0, "raise");
        chk(clk_level === 3'(LEVELS - 1), "R5 level saturated at top", clk_level, LEVELS - 1);
    endtask

    task automatic t_lower();
        for (int f = 0; f < 10; f++) run_frame(30, 170, 0, 0, 0, "lower");
        chk(clk_level === 3'd0, "R6 lowered to bottom", clk_level, 0);
    endtask

    task automatic t_idle_hold();
        run_frame(160, 6, 1, 1, 0, "hold");
        run_frame(160, 6, 1, 1, 0, "hold");
        for (int f = 0; f < 3; f++) run_frame(60, 6, 1, 1, 0, "hold");
        chk(clk_level === 3'd1, "R6 short idle blocks lowering", clk_level, 1);
    endtask

    task automatic t_window();
        cfg_busy_win_log2 = 3'd0; // R2 window of one frame
        run_frame(170, 6, 0, 0, 0, "busywin");
        chk(clk_level === 3'd2, "R2 single-frame window raises", clk_level, 2);
        cfg_busy_win_log2 = 3'd1;
        cfg_idle_win_log2 = 3'd0; // R3 window of one gap
        run_frame(40, 100, 0, 0, 0, "idlewin");
        run_frame(40, 100, 0, 0, 0, "idlewin");
        chk(clk_level === 3'd1, "R3 idle window lowers", clk_level, 1);
    endtask

    task automatic t_stray();
        cfg_idle_win_log2 = 3'd2;
        run_frame(100, 8, 1, 0, 1, "stray");
        run_frame(100, 8, 1, 0, 1, "stray");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_raise();
        t_lower();
        t_idle_hold();
        t_window();
        t_stray();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule